// File: doc/BRIEF.md
# Bounded Address Relocation Unit

This block sits between a processor's address generation and main memory. Every logical address that a user process presents is first compared against a per-process bound. If the address is inside the bound, a per-process base value is added to it to form the physical address. Each process is thereby confined to one contiguous partition of physical memory, and the process never observes where that partition lies.

An address that falls outside the bound never reaches memory. The block suppresses the access and raises a one-cycle trap pulse. It also keeps a copy of the offending logical address for the operating system's handler. The base and bound values can be loaded only while the supervisor-mode input is high. Requests issued in supervisor mode bypass the check and pass through untranslated. The compare and the add together take one registered stage.

Top module: `bound_xlate`

## Requirements
- R1: While and after synchronous reset, out_valid, trap, out_paddr and fault_addr are 0. The base and bound registers are 0, so the first user request after reset traps.
- R2: A user request (sup_mode=0) whose zero-extended logical address is strictly below the bound produces out_valid=1 and trap=0 one clock later. out_paddr then equals base plus logical address, taken modulo 2^PA_W.
- R3: A user request whose logical address is equal to or greater than the bound produces trap=1, out_valid=0 and out_paddr=0 one clock later. An address of bound-1 passes and an address equal to the bound traps.
- R4: The trap is high for exactly one cycle per failing request. In that same cycle, fault_addr shows the failing logical address, and it keeps that value until the next failing request.
- R5: A request made with sup_mode=1 returns out_valid=1, trap=0, and out_paddr equal to the zero-extended logical address one clock later, whatever the bound and base values are.
- R6: A configuration write with cfg_we=1 and sup_mode=1 loads cfg_wdata into the base register when cfg_sel=0 and into the bound register when cfg_sel=1. The new value applies to requests from the next cycle onward. A write made with sup_mode=0 changes neither register.
- R7: In a cycle after one without req_valid, out_valid and trap are both 0 and out_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | Supervisor mode: enables configuration writes and bypasses translation |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 base, 1 bound |
| cfg_wdata | input | PA_W (20) | Configuration write value |
| req_valid | input | 1 | Request present |
| req_laddr | input | LA_W (16) | Logical address of the request |
| out_valid | output | 1 | Physical address valid toward memory |
| out_paddr | output | PA_W (20) | Physical address |
| trap | output | 1 | Addressing-error pulse |
| fault_addr | output | LA_W (16) | Last logical address that trapped |

## Verification
Two situations are hard to reach from the ports. The first is an addition that overflows PA_W bits. The stimulus reaches it by loading a base value near the top of the physical space and then issuing a small legal offset. The second is showing that fault_addr holds between traps. The stimulus places a passing request and an idle cycle between two failing requests that carry different addresses, and reads fault_addr after each of them.

// File: rtl/bound_xlate_pkg.sv
package bound_xlate_pkg;

    localparam int LA_W_DEF = 16;
    localparam int PA_W_DEF = 20;

    typedef enum logic {
        TGT_BASE  = 1'b0,
        TGT_BOUND = 1'b1
    } cfg_tgt_e;

    typedef struct packed {
        logic pass;
        logic bypass;
        logic fail;
    } verdict_t;

    function automatic logic in_bounds(input logic [63:0] addr, input logic [63:0] bound);
        return addr < bound;
    endfunction

endpackage

// File: rtl/bx_cfg_regs.sv
module bx_cfg_regs
    import bound_xlate_pkg::*;
#(
    parameter int PA_W = PA_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup_mode,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    output logic [PA_W-1:0] base_q,
    output logic [PA_W-1:0] bound_q
);

    logic wr_ok;
    assign wr_ok = cfg_we && sup_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            bound_q <= '0;
        end else if (wr_ok) begin
            if (cfg_tgt_e'(cfg_sel) == TGT_BASE) base_q  <= cfg_wdata;
            else                                  bound_q <= cfg_wdata;
        end
    end

    // R6: writes outside supervisor mode leave both registers unchanged
    p_user_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !sup_mode) |=> ($stable(base_q) && $stable(bound_q)));

    // R1: both registers come out of reset cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (base_q == '0 && bound_q == '0));

endmodule

// File: rtl/bx_check.sv
module bx_check
    import bound_xlate_pkg::*;
#(
    parameter int LA_W = LA_W_DEF,
    parameter int PA_W = PA_W_DEF
) (
    input  logic            req_valid,
    input  logic            sup_mode,
    input  logic [LA_W-1:0] req_laddr,
    input  logic [PA_W-1:0] base_q,
    input  logic [PA_W-1:0] bound_q,
    output verdict_t        verdict,
    output logic [PA_W-1:0] paddr_next
);

    localparam int CW = (LA_W > PA_W) ? LA_W : PA_W;

    logic [CW-1:0]   la_ext;
    logic [CW-1:0]   bd_ext;
    logic [PA_W-1:0] la_pa;
    logic            ok;

    assign la_ext = CW'(req_laddr);
    assign bd_ext = CW'(bound_q);
    assign la_pa  = PA_W'(req_laddr);
    assign ok     = in_bounds(64'(la_ext), 64'(bd_ext));

    always_comb begin
        verdict    = '0;
        paddr_next = '0;
        if (req_valid) begin
            if (sup_mode) begin
                verdict.bypass = 1'b1;
                paddr_next     = la_pa;
            end else if (ok) begin
                verdict.pass = 1'b1;
                paddr_next   = la_pa + base_q;
            end else begin
                verdict.fail = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bx_out_stage.sv
module bx_out_stage
    import bound_xlate_pkg::*;
#(
    parameter int LA_W = LA_W_DEF,
    parameter int PA_W = PA_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            sup_mode,
    input  logic [LA_W-1:0] req_laddr,
    input  verdict_t        verdict,
    input  logic [PA_W-1:0] paddr_next,
    output logic            out_valid,
    output logic [PA_W-1:0] out_paddr,
    output logic            trap,
    output logic [LA_W-1:0] fault_addr
);

    logic fwd;
    assign fwd = verdict.pass | verdict.bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_paddr  <= '0;
            trap       <= 1'b0;
            fault_addr <= '0;
        end else begin
            out_valid <= fwd;
            out_paddr <= fwd ? paddr_next : '0;
            trap      <= verdict.fail;
            if (verdict.fail) fault_addr <= req_laddr;
        end
    end

    // R3: a blocked access never reaches memory
    p_trap_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        trap |-> (!out_valid && out_paddr == '0));

    // R7: outputs only follow a request
    p_valid_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid || trap) |-> $past(req_valid));

    // R4: fault register captures the trapping address
    p_fault_capture_r4: assert property (@(posedge clk) disable iff (rst)
        trap |-> (fault_addr == $past(req_laddr)));

    // R4: fault register holds when no failure enters
    p_fault_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !verdict.fail |=> $stable(fault_addr));

    // R5: supervisor requests never trap and always forward
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sup_mode) |=> (out_valid && !trap));

    // R2: at most one outcome per request
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(verdict));

endmodule

// File: rtl/bound_xlate.sv
module bound_xlate
    import bound_xlate_pkg::*;
#(
    parameter int LA_W = LA_W_DEF,
    parameter int PA_W = PA_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup_mode,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            req_valid,
    input  logic [LA_W-1:0] req_laddr,
    output logic            out_valid,
    output logic [PA_W-1:0] out_paddr,
    output logic            trap,
    output logic [LA_W-1:0] fault_addr
);

    logic [PA_W-1:0] base_q;
    logic [PA_W-1:0] bound_q;
    logic [PA_W-1:0] paddr_next;
    verdict_t        verdict;

    bx_cfg_regs #(.PA_W(PA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sup_mode  (sup_mode),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .bound_q   (bound_q)
    );

    bx_check #(.LA_W(LA_W), .PA_W(PA_W)) u_check (
        .req_valid  (req_valid),
        .sup_mode   (sup_mode),
        .req_laddr  (req_laddr),
        .base_q     (base_q),
        .bound_q    (bound_q),
        .verdict    (verdict),
        .paddr_next (paddr_next)
    );

    bx_out_stage #(.LA_W(LA_W), .PA_W(PA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .sup_mode   (sup_mode),
        .req_laddr  (req_laddr),
        .verdict    (verdict),
        .paddr_next (paddr_next),
        .out_valid  (out_valid),
        .out_paddr  (out_paddr),
        .trap       (trap),
        .fault_addr (fault_addr)
    );

endmodule

// File: tb/test_bound_xlate.sv
module test_bound_xlate;

    localparam int LA_W = 16;
    localparam int PA_W = 20;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic            sup;
        logic [LA_W-1:0] la;
        logic            exp_v;
        logic            exp_t;
        logic [PA_W-1:0] exp_pa;
    } vec_t;

    localparam int NV = 8;
    // base 0x12340, bound 0x00800
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 1'b1, 1'b0, 20'h12340},
        '{1'b0, 16'h07FF, 1'b1, 1'b0, 20'h12B3F},
        '{1'b0, 16'h0800, 1'b0, 1'b1, 20'h00000},
        '{1'b0, 16'hFFFF, 1'b0, 1'b1, 20'h00000},
        '{1'b0, 16'h0123, 1'b1, 1'b0, 20'h12463},
        '{1'b1, 16'hFFFF, 1'b1, 1'b0, 20'h0FFFF},
        '{1'b1, 16'h0800, 1'b1, 1'b0, 20'h00800},
        '{1'b0, 16'h0400, 1'b1, 1'b0, 20'h12740}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            sup_mode;
    logic            cfg_we;
    logic            cfg_sel;
    logic [PA_W-1:0] cfg_wdata;
    logic            req_valid;
    logic [LA_W-1:0] req_laddr;
    logic            out_valid;
    logic [PA_W-1:0] out_paddr;
    logic            trap;
    logic [LA_W-1:0] fault_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bound_xlate #(.LA_W(LA_W), .PA_W(PA_W)) i_bound_xlate (
        .clk(clk), .rst(rst), .sup_mode(sup_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_laddr(req_laddr), .out_valid(out_valid), .out_paddr(out_paddr),
        .trap(trap), .fault_addr(fault_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [PA_W-1:0] d, input logic sup);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; sup_mode = sup;
        @(negedge clk);
        cfg_we = 1'b0; sup_mode = 1'b0;
    endtask

    task automatic request(input logic sup, input logic [LA_W-1:0] la);
        @(negedge clk);
        req_valid = 1'b1; sup_mode = sup; req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0; sup_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sup_mode = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_wdata = '0; req_valid = 1'b0; req_laddr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 trap", 32'(trap), 0);
        check("R1 fault_addr", 32'(fault_addr), 0);
        request(1'b0, 16'h0000);
        check("R1 bound zero traps", 32'(trap), 1);
        check("R1 no forward", 32'(out_valid), 0);

        // R6: configure base and bound
        cfg_write(1'b0, 20'h12340, 1'b1);
        cfg_write(1'b1, 20'h00800, 1'b1);

        for (int i = 0; i < NV; i++) begin
            request(VECS[i].sup, VECS[i].la);
            check($sformatf("R2/R3/R5 vec%0d valid", i), 32'(out_valid), 32'(VECS[i].exp_v));
            check($sformatf("R2/R3/R5 vec%0d trap", i), 32'(trap), 32'(VECS[i].exp_t));
            check($sformatf("R2/R3/R5 vec%0d paddr", i), 32'(out_paddr), 32'(VECS[i].exp_pa));
            @(negedge clk);
            // R4 single pulse, R7 idle cycle
            check($sformatf("R4 vec%0d trap drops", i), 32'(trap), 0);
            check($sformatf("R7 vec%0d idle valid", i), 32'(out_valid), 0);
            check($sformatf("R7 vec%0d idle paddr", i), 32'(out_paddr), 0);
        end

        // R4: fault holds 0xFFFF (last failing vec) through passes, then updates
        check("R4 fault held", 32'(fault_addr), 32'h0000FFFF);
        request(1'b0, 16'h0900);
        check("R4 fault capture", 32'(fault_addr), 32'h00000900);
        check("R3 trap", 32'(trap), 1);
        request(1'b0, 16'h0010);
        check("R4 fault kept over pass", 32'(fault_addr), 32'h00000900);

        // R6: user-mode writes ignored
        cfg_write(1'b0, 20'hFFFFF, 1'b0);
        cfg_write(1'b1, 20'h00001, 1'b0);
        request(1'b0, 16'h0010);
        check("R6 user write ignored paddr", 32'(out_paddr), 32'h00012350);
        check("R6 user write ignored valid", 32'(out_valid), 1);

        // R6: supervisor write of bound applies to next request
        cfg_write(1'b1, 20'h00010, 1'b1);
        request(1'b0, 16'h0010);
        check("R6 new bound traps", 32'(trap), 1);
        request(1'b0, 16'h000F);
        check("R3 bound-1 passes", 32'(out_paddr), 32'h0001234F);

        // R2: modular wrap of the addition
        cfg_write(1'b0, 20'hFFFF0, 1'b1);
        cfg_write(1'b1, 20'h10000, 1'b1);
        request(1'b0, 16'h0020);
        check("R2 wrap paddr", 32'(out_paddr), 32'h00000010);
        request(1'b0, 16'hFFFF);
        check("R2 wide bound passes all", 32'(out_valid), 1);
        check("R2 wide bound paddr", 32'(out_paddr), 32'h0000FFEF);

        // R1: reset mid-run clears
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 fault cleared", 32'(fault_addr), 0);
        request(1'b0, 16'h0001);
        check("R1 bound cleared traps", 32'(trap), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule